// File: doc/BRIEF.md
# Descriptor Ring Pointer Engine

This block steps through a circular ring of 16-byte transfer descriptors for a single channel. Software supplies the ring's byte base address, the number of descriptors in the ring, and a head index: the first descriptor software has not yet handed over. The engine keeps its own tail index. Each time it finishes a descriptor, it moves the tail forward by one, and it wraps the tail to zero when the tail reaches the descriptor count. When tail equals head the ring is empty, and the engine waits until software moves the head.

Descriptors travel over a simple memory port with one request outstanding at a time. The port carries 64-bit words. The engine only touches the second word of each descriptor, at byte offset 8. That word holds, from bit 0 upward: a 12-bit length in [11:0], a 4-bit end-of-frame code in [15:12], a 4-bit start-of-frame code in [19:16], 12 flag bits in [31:20], and a 32-bit time word in [63:32].

The ring direction sets what the engine does with each descriptor:
- **Transmit ring:** the engine reads the word and presents the decoded fields on a transmit output strobe.
- **Receive ring:** the engine accepts a frame from the receive input and writes its shaped length and frame codes back into the descriptor.

The options word controls the ring. Bit 31 enables the ring and bit 30 selects raw mode. Every completed descriptor produces a one-cycle completion pulse tagged with the direction.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset, `ring_tail` is 0, and `mem_req`, `done`, `tx_valid` and `rx_ready` are all low.
- R2: Each completed descriptor advances `ring_tail` by one. When the next value would equal `ring_count`, `ring_tail` wraps to 0.
- R3: While `ring_tail` equals `sw_head`, the engine issues no memory request and holds `rx_ready` low for frames that pass the filter. Once `sw_head` moves, processing resumes.
- R4: On a transmit ring (`dir_rx`=0), the engine reads byte address `ring_base + 16*tail + 8`. It then shows the word's bits [11:0], [15:12], [19:16] and [31:20] on `tx_len`, `tx_eof`, `tx_sof` and `tx_flags`, with `tx_valid` asserted in the same cycle as `done`.
- R5: On a receive ring (`dir_rx`=1), the engine writes byte address `ring_base + 16*tail + 8`. The written word has the shaped length in [11:0], the frame's end code in [15:12] and its start code in [19:16], and zeros in [63:20].
- R6: With raw mode off (options bit 30 = 0), a frame is accepted only if `sof_mask[rx_sof]` and `eof_mask[rx_eof]` are both 1. A frame that fails this test is consumed with `rx_ready` but writes no descriptor and leaves `ring_tail` unchanged.
- R7: With raw mode on, both masks are ignored and the written length is the frame length as given. With raw mode off, 4 checksum bytes are removed from the length, saturating at 0.
- R8: The written length is clamped to the smaller of `rx_max_frame` and 0x100. Any `rx_max_frame` above 0x100 behaves exactly like 0x100.
- R9: When enable (options bit 31) is cleared, a request already in flight still completes. After that, `ring_tail` returns to 0 and no new request is issued.
- R10: `done` is high for exactly one cycle per completed descriptor. `done_rx` gives that descriptor's direction.
- R11: A raised `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_opts | input | 32 | Options word: bit 31 enable, bit 30 raw mode |
| dir_rx | input | 1 | 1 = receive ring, 0 = transmit ring |
| ring_base | input | AW | Byte base address of the ring |
| ring_count | input | IW | Number of descriptors in the ring |
| sw_head | input | IW | Software head index |
| rx_max_frame | input | 12 | Maximum receive frame size |
| sof_mask | input | 16 | Accepted start-of-frame codes, one bit per code |
| eof_mask | input | 16 | Accepted end-of-frame codes, one bit per code |
| ring_tail | output | IW | Hardware tail index |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 64 | Read data |
| rx_valid | input | 1 | Received frame offered |
| rx_len | input | 12 | Received frame length in bytes |
| rx_sof | input | 4 | Received start-of-frame code |
| rx_eof | input | 4 | Received end-of-frame code |
| rx_ready | output | 1 | Frame taken in this cycle |
| tx_valid | output | 1 | Decoded transmit descriptor strobe |
| tx_len | output | 12 | Transmit length |
| tx_sof | output | 4 | Transmit start-of-frame code |
| tx_eof | output | 4 | Transmit end-of-frame code |
| tx_flags | output | 12 | Transmit flag bits |
| done | output | 1 | One-cycle completion pulse |
| done_rx | output | 1 | Direction of the completed descriptor |

## Verification
A wrong tail value is visible on the very next memory request, because the request address is built from the tail. It is also checked against a reference tail on every clock, so a wrong wrap or a missed clear is reported in the cycle it happens. Errors in the receive length shaping or the frame filter land in memory. They show up as a wrong written word, or as a descriptor written when it should have been skipped, as soon as the bench reads the ring contents after each scenario.

// File: rtl/ring_eng_pkg.sv
package ring_eng_pkg;
   localparam int LEN_W  = 12;
   localparam int CODE_W = 4;
   localparam int FLG_W  = 12;
   localparam int NCODES = 1 << CODE_W;

   // Second 64-bit word of a descriptor; members listed MSB first.
   typedef struct packed {
      logic [31:0]       stamp;
      logic [FLG_W-1:0]  flags;
      logic [CODE_W-1:0] sof;
      logic [CODE_W-1:0] eof;
      logic [LEN_W-1:0]  len;
   } desc_word_t;
endpackage

// File: rtl/ring_tail_ctr.sv
module ring_tail_ctr #(
   parameter int IW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [IW-1:0] count,
   input  logic [IW-1:0] head,
   output logic [IW-1:0] tail,
   output logic          empty
);
   logic [IW-1:0] nxt;

   assign nxt   = tail + IW'(1);
   assign empty = (tail == head);

   always_ff @(posedge clk) begin
      if (!rst_n)
         tail <= '0;
      else if (clr)
         tail <= '0;
      else if (adv)
         tail <= (nxt == count) ? '0 : nxt;
   end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
   parameter int AW = 16,
   parameter int IW = 4
)(
   input  logic [AW-1:0] base,
   input  logic [IW-1:0] tail,
   output logic [AW-1:0] addr
);
   localparam int DESC_SHIFT = 4;   // 16-byte descriptors
   localparam int WORD1_OFS  = 8;   // length/code word offset

   assign addr = base + (AW'(tail) << DESC_SHIFT) + AW'(WORD1_OFS);
endmodule

// File: rtl/ring_rx_shaper.sv
module ring_rx_shaper
   import ring_eng_pkg::*;
#(
   parameter int CKSUM_BYTES = 4,
   parameter int FRAME_CAP   = 256
)(
   input  logic              raw,
   input  logic [LEN_W-1:0]  len,
   input  logic [CODE_W-1:0] sof,
   input  logic [CODE_W-1:0] eof,
   input  logic [NCODES-1:0] sof_mask,
   input  logic [NCODES-1:0] eof_mask,
   input  logic [LEN_W-1:0]  max_frame,
   output logic              pass,
   output desc_word_t        word
);
   localparam logic [LEN_W-1:0] CAP = LEN_W'(FRAME_CAP);

   logic [LEN_W-1:0] stripped;
   logic [LEN_W-1:0] limit;
   logic [LEN_W-1:0] shaped;

   generate
      if (CKSUM_BYTES == 0) begin : g_no_cksum
         assign stripped = len;
      end else begin : g_cksum
         localparam logic [LEN_W-1:0] CK = LEN_W'(CKSUM_BYTES);
         always_comb begin
            if (raw)
               stripped = len;
            else if (len > CK)
               stripped = len - CK;
            else
               stripped = '0;
         end
      end
   endgenerate

   assign limit  = (max_frame > CAP) ? CAP : max_frame;
   assign shaped = (stripped > limit) ? limit : stripped;
   assign pass   = raw || (sof_mask[sof] && eof_mask[eof]);

   always_comb begin
      word       = '0;
      word.sof   = sof;
      word.eof   = eof;
      word.len   = shaped;
   end
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
   import ring_eng_pkg::*;
#(
   parameter int AW          = 16,
   parameter int IW          = 4,
   parameter int CKSUM_BYTES = 4,
   parameter int FRAME_CAP   = 256
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ring_opts,
   input  logic              dir_rx,
   input  logic [AW-1:0]     ring_base,
   input  logic [IW-1:0]     ring_count,
   input  logic [IW-1:0]     sw_head,
   input  logic [11:0]       rx_max_frame,
   input  logic [15:0]       sof_mask,
   input  logic [15:0]       eof_mask,
   output logic [IW-1:0]     ring_tail,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [63:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [63:0]       mem_rdata,
   input  logic              rx_valid,
   input  logic [11:0]       rx_len,
   input  logic [3:0]        rx_sof,
   input  logic [3:0]        rx_eof,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [11:0]       tx_len,
   output logic [3:0]        tx_sof,
   output logic [3:0]        tx_eof,
   output logic [11:0]       tx_flags,
   output logic              done,
   output logic              done_rx
);
   localparam int EN_BIT  = 31;
   localparam int RAW_BIT = 30;

   generate
      if (AW < IW + 5) begin : g_bad_aw
         $error("desc_ring_engine: AW too narrow for IW descriptors");
      end
      if (FRAME_CAP >= (1 << LEN_W)) begin : g_bad_cap
         $error("desc_ring_engine: FRAME_CAP exceeds length field");
      end
      if (CKSUM_BYTES < 0 || CKSUM_BYTES > 15) begin : g_bad_ck
         $error("desc_ring_engine: CKSUM_BYTES out of range");
      end
   endgenerate

   logic       ring_en, raw_mode;
   logic       busy_q, we_q;
   desc_word_t wdata_q;
   desc_word_t rx_word, rd_word;
   logic       rx_pass, ring_empty;
   logic       launch_tx, launch_rx, take_rx;
   logic       tail_adv, tail_clr;
   logic       unused_bits;

   assign ring_en  = ring_opts[EN_BIT];
   assign raw_mode = ring_opts[RAW_BIT];
   assign rd_word  = desc_word_t'(mem_rdata);
   assign unused_bits = ^{rd_word.stamp, ring_opts[29:0]};

   ring_rx_shaper #(
      .CKSUM_BYTES (CKSUM_BYTES),
      .FRAME_CAP   (FRAME_CAP)
   ) u_shape (
      .raw       (raw_mode),
      .len       (rx_len),
      .sof       (rx_sof),
      .eof       (rx_eof),
      .sof_mask  (sof_mask),
      .eof_mask  (eof_mask),
      .max_frame (rx_max_frame),
      .pass      (rx_pass),
      .word      (rx_word)
   );

   ring_tail_ctr #(.IW(IW)) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tail_clr),
      .adv   (tail_adv),
      .count (ring_count),
      .head  (sw_head),
      .tail  (ring_tail),
      .empty (ring_empty)
   );

   ring_addr_gen #(.AW(AW), .IW(IW)) u_addr (
      .base (ring_base),
      .tail (ring_tail),
      .addr (mem_addr)
   );

   assign take_rx   = !busy_q && ring_en && dir_rx && rx_valid && (!rx_pass || !ring_empty);
   assign launch_rx = take_rx && rx_pass;
   assign launch_tx = !busy_q && ring_en && !dir_rx && !ring_empty;
   assign tail_adv  = busy_q && mem_ack;
   assign tail_clr  = !busy_q && !ring_en;

   assign rx_ready  = take_rx;
   assign mem_req   = busy_q;
   assign mem_we    = we_q;
   assign mem_wdata = wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         we_q     <= 1'b0;
         wdata_q  <= '0;
         done     <= 1'b0;
         done_rx  <= 1'b0;
         tx_valid <= 1'b0;
         tx_len   <= '0;
         tx_sof   <= '0;
         tx_eof   <= '0;
         tx_flags <= '0;
      end else begin
         done     <= 1'b0;
         tx_valid <= 1'b0;
         if (busy_q) begin
            if (mem_ack) begin
               busy_q  <= 1'b0;
               done    <= 1'b1;
               done_rx <= we_q;
               if (!we_q) begin
                  tx_valid <= 1'b1;
                  tx_len   <= rd_word.len;
                  tx_sof   <= rd_word.sof;
                  tx_eof   <= rd_word.eof;
                  tx_flags <= rd_word.flags;
               end
            end
         end else if (launch_tx) begin
            busy_q <= 1'b1;
            we_q   <= 1'b0;
         end else if (launch_rx) begin
            busy_q  <= 1'b1;
            we_q    <= 1'b1;
            wdata_q <= rx_word;
         end
      end
   end
endmodule

// File: rtl/ring_engine_chk.sv
module ring_engine_chk #(
   parameter int AW = 16,
   parameter int IW = 4
)(
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic [IW-1:0] ring_count,
   input logic [IW-1:0] sw_head,
   input logic [IW-1:0] ring_tail,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [43:0]   wr_hi,
   input logic          done,
   input logic          done_rx,
   input logic          tx_valid,
   input logic          rx_ready
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
   AST_NO_FETCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(ring_tail != sw_head)); // R3
   AST_WR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> wr_hi == '0); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !mem_req |=> ring_tail == '0); // R9
   AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> done && !done_rx); // R4
   AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done && ring_count != '0 |-> ring_tail < ring_count); // R2
   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> !mem_req && en); // R6
endmodule

bind desc_ring_engine ring_engine_chk #(.AW(AW), .IW(IW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (ring_opts[31]),
   .ring_count (ring_count),
   .sw_head    (sw_head),
   .ring_tail  (ring_tail),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .wr_hi      (mem_wdata[63:20]),
   .done       (done),
   .done_rx    (done_rx),
   .tx_valid   (tx_valid),
   .rx_ready   (rx_ready)
);

// File: tb/desc_ring_engine_test.sv
module desc_ring_engine_test;
   localparam int AW = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   ring_opts = '0;
   logic          dir_rx = 1'b0;
   logic [AW-1:0] ring_base = '0;
   logic [IW-1:0] ring_count = '0;
   logic [IW-1:0] sw_head = '0;
   logic [11:0]   rx_max_frame = '0;
   logic [15:0]   sof_mask = '0;
   logic [15:0]   eof_mask = '0;
   logic [IW-1:0] ring_tail;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [63:0]   mem_wdata;
   logic          mem_ack = 1'b0;
   logic [63:0]   mem_rdata = '0;
   logic          rx_valid = 1'b0;
   logic [11:0]   rx_len = '0;
   logic [3:0]    rx_sof = '0, rx_eof = '0;
   logic          rx_ready, tx_valid, done, done_rx;
   logic [11:0]   tx_len, tx_flags;
   logic [3:0]    tx_sof, tx_eof;

   int n_tests = 0, n_fail = 0, tx_cnt = 0, wr_cnt = 0;
   logic [63:0] mem [0:127];
   logic [63:0] exp_q [$];
   int  m_tail = 0;
   bit  m_done = 0, m_done_rx = 0, finished = 0;

   always #5 clk = ~clk;

   desc_ring_engine #(.AW(AW), .IW(IW)) uut (.*);

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: one wait cycle, ack for one cycle
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[9:3]];
      end else if (mem_req && mem_ack) begin
         mem_ack <= 1'b0;
         if (mem_we) mem[mem_addr[9:3]] <= mem_wdata;
      end
   end

   // behavioural reference for tail and completion
   always @(posedge clk) begin
      if (!rst_n) begin
         m_tail = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (mem_req && mem_ack) begin
            m_done = 1; m_done_rx = mem_we;
            chk(mem_addr == AW'(int'(ring_base) + m_tail * 16 + 8),
                mem_we ? "R5 address" : "R4 address", mem_addr, int'(ring_base) + m_tail * 16 + 8);
            if (mem_we) wr_cnt++;
            else exp_q.push_back(mem[mem_addr[9:3]]);
            m_tail = (m_tail + 1 == int'(ring_count)) ? 0 : m_tail + 1;
         end else if (!ring_opts[31] && !mem_req) begin
            m_tail = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(ring_tail == IW'(m_tail), "R2 tail", ring_tail, m_tail);
         chk(done == m_done, "R10 done", done, m_done);
         if (done) chk(done_rx == m_done_rx, "R10 done_rx", done_rx, m_done_rx);
         if (tx_valid) begin
            logic [63:0] w;
            w = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hx;
            chk({tx_flags, tx_sof, tx_eof, tx_len} == w[31:0], "R4 fields",
                {tx_flags, tx_sof, tx_eof, tx_len}, w[31:0]);
            tx_cnt++;
         end
      end
   end

   task automatic wait_tx(input int n);
      for (int g = 0; g < 300 && tx_cnt < n; g++) @(negedge clk);
   endtask

   task automatic send_frame(input int len, input int s, input int e);
      @(negedge clk);
      rx_valid = 1'b1; rx_len = 12'(len); rx_sof = 4'(s); rx_eof = 4'(e);
      #1;
      for (int g = 0; g < 100 && !rx_ready; g++) begin @(negedge clk); #1; end
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 64'h5A5A_0000_0000_0000 + 64'(i);
      for (int i = 0; i < 4; i++)
         mem[33 + 2 * i] = {32'h0, 12'(12'h0A0 + i), 4'(i + 1), 4'(i + 8), 12'(16 * i + 5)};
      repeat (3) @(negedge clk);
      chk(ring_tail == 0, "R1 tail", ring_tail, 0);
      chk(!mem_req && !done && !tx_valid && !rx_ready, "R1 outputs",
          {mem_req, done, tx_valid, rx_ready}, 0);
      rst_n = 1'b1;

      // transmit ring, empty then posted
      ring_base = 16'h0100; ring_count = 4; sw_head = 0; ring_opts = 32'h8000_0000;
      for (int i = 0; i < 6; i++) begin @(negedge clk); chk(!mem_req, "R3 empty no fetch", mem_req, 0); end
      sw_head = 3;
      wait_tx(3); repeat (4) @(negedge clk);
      chk(tx_cnt == 3, "R4 count", tx_cnt, 3);
      chk(ring_tail == 3, "R2 advance", ring_tail, 3);
      sw_head = 1;
      wait_tx(5); repeat (4) @(negedge clk);
      chk(tx_cnt == 5, "R2 wrap count", tx_cnt, 5);
      chk(ring_tail == 1, "R2 wrap", ring_tail, 1);

      // disable clears tail; disable with request in flight
      ring_opts = 32'h0; repeat (2) @(negedge clk);
      chk(ring_tail == 0, "R9 clear", ring_tail, 0);
      sw_head = 2; ring_opts = 32'h8000_0000;
      for (int g = 0; g < 20 && !mem_req; g++) @(negedge clk);
      ring_opts = 32'h0;
      repeat (10) @(negedge clk);
      chk(tx_cnt == 6, "R9 in-flight completes", tx_cnt, 6);
      chk(ring_tail == 0 && !mem_req, "R9 stopped", {ring_tail, mem_req}, 0);

      // receive ring
      dir_rx = 1'b1; ring_base = 16'h0200; ring_count = 3; sw_head = 2;
      rx_max_frame = 12'h300; sof_mask = 16'h0002; eof_mask = 16'h0004;
      mem[67] = 64'hDEAD_BEEF_0000_1234;
      ring_opts = 32'h8000_0000;
      send_frame(100, 1, 2);
      chk(mem[65] == {32'h0, 12'h0, 4'd1, 4'd2, 12'd96}, "R5 R7 strip write", mem[65],
          {32'h0, 12'h0, 4'd1, 4'd2, 12'd96});
      send_frame(80, 3, 2);
      chk(wr_cnt == 1 && ring_tail == 1, "R6 drop no write", {wr_cnt, ring_tail}, {1, 1});
      chk(mem[67] == 64'hDEAD_BEEF_0000_1234, "R6 desc untouched", mem[67], 64'hDEAD_BEEF_0000_1234);
      send_frame(600, 1, 2);
      chk(mem[67] == {32'h0, 12'h0, 4'd1, 4'd2, 12'h100}, "R8 clamp", mem[67],
          {32'h0, 12'h0, 4'd1, 4'd2, 12'h100});
      // ring now empty (tail 2 = head 2); raw frame waits
      ring_opts = 32'hC000_0000;
      @(negedge clk);
      rx_valid = 1'b1; rx_len = 12'd50; rx_sof = 4'd5; rx_eof = 4'd7;
      for (int i = 0; i < 5; i++) begin @(negedge clk); #1; chk(!rx_ready, "R3 rx stall", rx_ready, 0); end
      sw_head = 1; #1;
      for (int g = 0; g < 100 && !rx_ready; g++) begin @(negedge clk); #1; end
      @(negedge clk); rx_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk(mem[69] == {32'h0, 12'h0, 4'd5, 4'd7, 12'd50}, "R7 raw keep", mem[69],
          {32'h0, 12'h0, 4'd5, 4'd7, 12'd50});
      send_frame(300, 0, 0);
      chk(mem[65] == {32'h0, 12'h0, 4'd0, 4'd0, 12'h100}, "R8 raw clamp wrap", mem[65],
          {32'h0, 12'h0, 4'd0, 4'd0, 12'h100});
      chk(ring_tail == 1 && wr_cnt == 4, "R2 rx wrap", {ring_tail, wr_cnt}, {1, 4});

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule